// File: doc/BRIEF.md
# Cascadable Up/Down Timer Pair with Toggle Latch

The block holds two 16-bit up/down timers and a one-bit toggle latch between them. The core timer advances in one of three ways. In free-run mode it counts on a prescaled clock enable. In gated mode it counts on that enable only while a gate input is high. In event mode it counts on rising edges of an external input. Each time the core timer wraps in either direction, the toggle latch inverts.

The auxiliary timer is a pure event counter. Its source is either the toggle latch or its own external input. An edge-select field decides which transitions of that source advance it. Selecting both edges makes the auxiliary timer step once per core wrap, so the pair acts as a 32-bit counter. Selecting only one edge makes it step once per two core wraps. The pair is then a 33-bit counter: the core timer forms the low 16 bits, the latch forms bit 16 and the auxiliary timer forms the top 16 bits. Each half has its own count direction.

Software can load either timer and the latch directly. A latch write that makes a selected transition is counted like a hardware toggle. The auxiliary timer's run enable can follow the core timer's run bit. Every wrap of either timer gives a one-cycle interrupt pulse. All inputs are plain synchronous control pins. The block has no streaming data path.

Top module: `chain_timer`

## Requirements
- R1: During and right after reset, both timer values are 0x0000, the latch is 0 and both interrupt outputs are 0.
- R2: A timer that counts up from 0xFFFF goes to 0x0000, and one that counts down from 0x0000 goes to 0xFFFF. For the core timer, the wrap inverts `lat_q` at the same clock edge. Each timer's irq output is high for exactly the one cycle after its wrap.
- R3: `core_down`=1 makes the core timer count down and 0 makes it count up. `aux_down` sets the auxiliary timer's direction on its own, so the two halves may count in opposite directions.
- R4: `core_mode` is encoded as follows: 2'b00 counts on each cycle with `presc_en`=1. 2'b01 counts on each cycle with both `presc_en`=1 and `gate_in`=1. 2'b11 never counts. The core timer counts only while `core_run`=1.
- R5: With `core_mode`=2'b10, the core timer advances once per rising edge of `core_ext_in` and ignores `presc_en`.
- R6: With `aux_edge_sel`=2'b11 and the latch as source, the auxiliary timer advances once per core wrap (32-bit cascade).
- R7: With `aux_edge_sel`=2'b10 (falling only) or 2'b01 (rising only), the auxiliary timer advances once per two core wraps. With falling selected and both halves counting up, {aux_val, lat_q, core_val} reads as one 33-bit count.
- R8: With `aux_edge_sel`=2'b00, no source transition advances the auxiliary timer.
- R9: A latch write sets `lat_q` at the next clock edge. If the write makes a selected transition, the auxiliary timer counts it. An unselected transition is not counted.
- R10: A timer write in the same cycle as a count loads the written value. No step is applied, no wrap is raised and the latch does not toggle.
- R11: With `aux_remote`=1, the auxiliary timer's run enable is `core_run`. With `aux_remote`=0, it is `aux_run`.
- R12: `aux_src_latch`=1 takes the latch as the auxiliary source and 0 takes `aux_ext_in`. The same edge selection applies to both. Latch toggles have no effect while the pin is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_en | input | 1 | Prescaled count enable |
| gate_in | input | 1 | Gate for gated mode, active high |
| core_ext_in | input | 1 | Core external count input |
| aux_ext_in | input | 1 | Auxiliary external count input |
| core_run | input | 1 | Core run bit |
| aux_run | input | 1 | Auxiliary run bit |
| aux_remote | input | 1 | 1: auxiliary run follows core_run |
| core_mode | input | 2 | Core mode select |
| core_down | input | 1 | Core direction, 1 = down |
| aux_down | input | 1 | Auxiliary direction, 1 = down |
| aux_edge_sel | input | 2 | Auxiliary source edge select |
| aux_src_latch | input | 1 | 1: latch source, 0: pin source |
| core_wr | input | 1 | Core timer write strobe |
| core_wdata | input | 16 | Core timer write value |
| aux_wr | input | 1 | Auxiliary timer write strobe |
| aux_wdata | input | 16 | Auxiliary timer write value |
| lat_wr | input | 1 | Latch write strobe |
| lat_wdata | input | 1 | Latch write value |
| core_val | output | 16 | Core timer value |
| aux_val | output | 16 | Auxiliary timer value |
| lat_q | output | 1 | Toggle latch state |
| core_irq | output | 1 | Core wrap pulse |
| aux_irq | output | 1 | Auxiliary wrap pulse |

## Verification
The properties assume that every input is synchronous to the clock. They also assume that the auxiliary source is switched only while the edge selection is 2'b00, because a switch could otherwise look like an edge. The bench changes every input on the falling clock edge. It switches the source only in a preparation step that clears the edge selection and lets the delayed copy settle for two cycles before a new selection is applied.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_GATED = 2'b01,
    MODE_EVENT = 2'b10,
    MODE_HOLD  = 2'b11
  } core_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         down,
  input  logic         load,
  input  logic [W-1:0] ldata,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // a load always wins, so no wrap can be raised in a write cycle
  assign wrap = step && !load && (down ? (val == '0) : (val == TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (load) begin
      val <= ldata;
    end else if (step) begin
      val <= down ? val - 1'b1 : val + 1'b1;
    end
  end
endmodule

// File: rtl/ct_edge.sv
module ct_edge
  import chain_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  input  logic [1:0] sel,
  output logic       tick
);
  logic sig_d;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_d <= 1'b0;
    else        sig_d <= sig;
  end

  always_comb begin
    unique case (edge_sel_e'(sel))
      EDGE_RISE: tick = sig & ~sig_d;
      EDGE_FALL: tick = ~sig & sig_d;
      EDGE_BOTH: tick = sig ^ sig_d;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/ct_toggle.sv
module ct_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (wr)   q <= wdata;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import chain_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         presc_en,
  input  logic         gate_in,
  input  logic         core_ext_in,
  input  logic         aux_ext_in,
  input  logic         core_run,
  input  logic         aux_run,
  input  logic         aux_remote,
  input  logic [1:0]   core_mode,
  input  logic         core_down,
  input  logic         aux_down,
  input  logic [1:0]   aux_edge_sel,
  input  logic         aux_src_latch,
  input  logic         core_wr,
  input  logic [W-1:0] core_wdata,
  input  logic         aux_wr,
  input  logic [W-1:0] aux_wdata,
  input  logic         lat_wr,
  input  logic         lat_wdata,
  output logic [W-1:0] core_val,
  output logic [W-1:0] aux_val,
  output logic         lat_q,
  output logic         core_irq,
  output logic         aux_irq
);
  logic ext_rise, core_step, core_wrap;
  logic aux_src, aux_tick, aux_go, aux_step, aux_wrap;

  ct_edge u_ext_edge (
    .clk(clk), .rst_n(rst_n), .sig(core_ext_in),
    .sel(EDGE_RISE), .tick(ext_rise)
  );

  always_comb begin
    unique case (core_mode_e'(core_mode))
      MODE_FREE:  core_step = core_run & presc_en;
      MODE_GATED: core_step = core_run & presc_en & gate_in;
      MODE_EVENT: core_step = core_run & ext_rise;
      default:    core_step = 1'b0;
    endcase
  end

  ct_counter #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(core_step), .down(core_down),
    .load(core_wr), .ldata(core_wdata), .val(core_val), .wrap(core_wrap)
  );

  ct_toggle u_latch (
    .clk(clk), .rst_n(rst_n), .wr(lat_wr), .wdata(lat_wdata),
    .flip(core_wrap), .q(lat_q)
  );

  assign aux_src = aux_src_latch ? lat_q : aux_ext_in;

  ct_edge u_aux_edge (
    .clk(clk), .rst_n(rst_n), .sig(aux_src),
    .sel(aux_edge_sel), .tick(aux_tick)
  );

  assign aux_go   = aux_remote ? core_run : aux_run;
  assign aux_step = aux_go & aux_tick;

  ct_counter #(.W(W)) u_aux (
    .clk(clk), .rst_n(rst_n), .step(aux_step), .down(aux_down),
    .load(aux_wr), .ldata(aux_wdata), .val(aux_val), .wrap(aux_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_irq <= 1'b0;
      aux_irq  <= 1'b0;
    end else begin
      core_irq <= core_wrap;
      aux_irq  <= aux_wrap;
    end
  end
endmodule

// File: rtl/chain_timer_chk.sv
module chain_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         core_run,
  input logic [1:0]   core_mode,
  input logic [1:0]   aux_edge_sel,
  input logic         core_wr,
  input logic [W-1:0] core_wdata,
  input logic         aux_wr,
  input logic [W-1:0] aux_wdata,
  input logic         lat_wr,
  input logic [W-1:0] core_val,
  input logic [W-1:0] aux_val,
  input logic         lat_q,
  input logic         core_irq,
  input logic         aux_irq
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assert_lat_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq && !$past(lat_wr)) |-> (lat_q != $past(lat_q)));

  assert_core_wrapval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (core_val == '0 || core_val == TOP));

  assert_aux_wrapval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> (aux_val == '0 || aux_val == TOP));

  assert_core_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(core_wr) |-> (core_val == $past(core_val) ||
                         core_val == $past(core_val) + 1'b1 ||
                         core_val == $past(core_val) - 1'b1));

  assert_aux_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(aux_wr) |-> (aux_val == $past(aux_val) ||
                        aux_val == $past(aux_val) + 1'b1 ||
                        aux_val == $past(aux_val) - 1'b1));

  assert_core_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(core_run) || $past(core_mode) == 2'b11) && !$past(core_wr))
      |-> (core_val == $past(core_val)));

  assert_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(aux_edge_sel) == 2'b00 && !$past(aux_wr))
      |-> (aux_val == $past(aux_val)));

  assert_core_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_wr) |-> (core_val == $past(core_wdata)));

  assert_aux_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(aux_wr) |-> (aux_val == $past(aux_wdata)));
endmodule

bind chain_timer chain_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .core_run(core_run), .core_mode(core_mode),
  .aux_edge_sel(aux_edge_sel), .core_wr(core_wr), .core_wdata(core_wdata),
  .aux_wr(aux_wr), .aux_wdata(aux_wdata), .lat_wr(lat_wr),
  .core_val(core_val), .aux_val(aux_val), .lat_q(lat_q),
  .core_irq(core_irq), .aux_irq(aux_irq)
);

// File: tb/chain_timer_tb.sv
`timescale 1ns/1ps
module chain_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        presc_en = 0, gate_in = 0, core_ext_in = 0, aux_ext_in = 0;
  logic        core_run = 0, aux_run = 0, aux_remote = 0;
  logic [1:0]  core_mode = 2'b00;
  logic        core_down = 0, aux_down = 0;
  logic [1:0]  aux_edge_sel = 2'b00;
  logic        aux_src_latch = 1;
  logic        core_wr = 0, aux_wr = 0, lat_wr = 0, lat_wdata = 0;
  logic [15:0] core_wdata = '0, aux_wdata = '0;
  logic [15:0] core_val, aux_val;
  logic        lat_q, core_irq, aux_irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  chain_timer dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_core(input logic [15:0] v);
    core_wr = 1; core_wdata = v; @(negedge clk); core_wr = 0;
  endtask

  task automatic write_aux(input logic [15:0] v);
    aux_wr = 1; aux_wdata = v; @(negedge clk); aux_wr = 0;
  endtask

  task automatic write_lat(input logic v);
    lat_wr = 1; lat_wdata = v; @(negedge clk); lat_wr = 0;
  endtask

  task automatic tick_core();
    presc_en = 1; @(negedge clk); presc_en = 0;
  endtask

  task automatic prep();
    aux_edge_sel = 2'b00; aux_run = 0; aux_remote = 0; aux_src_latch = 1;
    core_mode = 2'b00; core_run = 1; core_down = 0; aux_down = 0;
    write_lat(1'b0);
    idle(2);
  endtask

  task automatic t_reset();
    check("R1 core_val", core_val, 0);
    check("R1 aux_val", aux_val, 0);
    check("R1 lat_q", lat_q, 0);
    check("R1 irqs", {core_irq, aux_irq}, 0);
  endtask

  task automatic t_up_wrap();
    prep();
    write_core(16'hFFFE);
    tick_core();
    check("R2 up pre", core_val, 16'hFFFF);
    check("R2 no irq", core_irq, 0);
    tick_core();
    check("R2 up wrap", core_val, 0);
    check("R2 irq", core_irq, 1);
    check("R2 lat flip", lat_q, 1);
    idle(1);
    check("R2 irq one cycle", core_irq, 0);
  endtask

  task automatic t_down_wrap();
    prep();
    core_down = 1;
    write_core(16'h0001);
    tick_core();
    check("R3 down step", core_val, 0);
    tick_core();
    check("R2 down wrap", core_val, 16'hFFFF);
    check("R2 down irq", core_irq, 1);
    check("R2 down lat", lat_q, 1);
  endtask

  task automatic t_gated();
    prep();
    core_mode = 2'b01;
    write_core(16'h0010);
    gate_in = 0; presc_en = 1; idle(4);
    check("R4 gate low", core_val, 16'h0010);
    gate_in = 1; idle(3); presc_en = 0; gate_in = 0;
    check("R4 gate high", core_val, 16'h0013);
    core_mode = 2'b00; idle(3);
    check("R4 free no presc", core_val, 16'h0013);
    core_mode = 2'b11; presc_en = 1; idle(3); presc_en = 0;
    check("R4 hold", core_val, 16'h0013);
    core_mode = 2'b00; core_run = 0; presc_en = 1; idle(3); presc_en = 0;
    check("R4 not run", core_val, 16'h0013);
  endtask

  task automatic t_event();
    prep();
    core_mode = 2'b10;
    write_core(16'h0100);
    presc_en = 1;
    for (int i = 0; i < 3; i++) begin
      core_ext_in = 1; idle(2); core_ext_in = 0; idle(2);
    end
    presc_en = 0;
    check("R5 event count", core_val, 16'h0103);
  endtask

  task automatic t_cascade32();
    prep();
    aux_edge_sel = 2'b11; aux_run = 1; aux_down = 1;
    write_aux(16'h0001);
    write_core(16'hFFFF);
    tick_core();
    check("R6 lat after wrap", lat_q, 1);
    idle(1);
    check("R6 aux step 1", aux_val, 0);
    write_core(16'hFFFF);
    tick_core();
    idle(1);
    check("R6 aux step 2 opposite dir R3", aux_val, 16'hFFFF);
    check("R2 aux irq", aux_irq, 1);
    idle(1);
    check("R2 aux irq one cycle", aux_irq, 0);
  endtask

  task automatic t_cascade33();
    prep();
    aux_edge_sel = 2'b10; aux_run = 1;
    write_aux(16'h0000);
    write_core(16'hFFFF);
    tick_core(); idle(2);
    check("R7 33b first", {31'b0, aux_val, lat_q, core_val}, 64'h1_0000);
    write_core(16'hFFFF);
    tick_core(); idle(2);
    check("R7 33b second", {31'b0, aux_val, lat_q, core_val}, 64'h2_0000);
    aux_edge_sel = 2'b01;
    write_core(16'hFFFF);
    tick_core(); idle(2);
    check("R7 rising only", aux_val, 16'h0002);
  endtask

  task automatic t_sw_latch();
    prep();
    aux_edge_sel = 2'b01; aux_run = 1;
    write_aux(16'h000A);
    write_lat(1'b1);
    check("R9 lat immediate", lat_q, 1);
    idle(2);
    check("R9 sw rise counted", aux_val, 16'h000B);
    write_lat(1'b0);
    idle(2);
    check("R9 sw fall ignored", aux_val, 16'h000B);
  endtask

  task automatic t_sel_none();
    prep();
    aux_run = 1;
    write_aux(16'h0007);
    for (int i = 0; i < 2; i++) begin
      write_core(16'hFFFF); tick_core();
    end
    idle(2);
    check("R8 lat toggled twice", lat_q, 0);
    check("R8 aux unchanged", aux_val, 16'h0007);
  endtask

  task automatic t_prio();
    prep();
    write_core(16'h1230);
    presc_en = 1; core_wr = 1; core_wdata = 16'h1234;
    @(negedge clk); core_wr = 0;
    check("R10 load over count", core_val, 16'h1234);
    @(negedge clk); presc_en = 0;
    check("R10 counts after", core_val, 16'h1235);
    write_core(16'hFFFF);
    presc_en = 1; core_wr = 1; core_wdata = 16'h0005;
    @(negedge clk); core_wr = 0; presc_en = 0;
    check("R10 load at wrap", core_val, 16'h0005);
    check("R10 no irq", core_irq, 0);
    check("R10 no flip", lat_q, 0);
  endtask

  task automatic t_remote();
    prep();
    aux_edge_sel = 2'b11; aux_run = 0; aux_remote = 1;
    write_aux(16'h0014);
    write_core(16'hFFFF); tick_core(); idle(1);
    check("R11 remote run", aux_val, 16'h0015);
    aux_remote = 0;
    write_core(16'hFFFF); tick_core(); idle(2);
    check("R11 own run off", aux_val, 16'h0015);
  endtask

  task automatic t_src_pin();
    prep();
    aux_src_latch = 0; aux_run = 1;
    write_aux(16'h001E);
    idle(2);
    aux_edge_sel = 2'b01;
    aux_ext_in = 1; idle(3);
    check("R12 pin edge", aux_val, 16'h001F);
    aux_ext_in = 0; idle(2);
    write_core(16'hFFFF); tick_core(); idle(2);
    check("R12 lat toggled", lat_q, 1);
    check("R12 lat ignored", aux_val, 16'h001F);
    prep();
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(1);
    t_reset();
    t_up_wrap();
    t_down_wrap();
    t_gated();
    t_event();
    t_cascade32();
    t_cascade33();
    t_sw_latch();
    t_sel_none();
    t_prio();
    t_remote();
    t_src_pin();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule